// File: doc/BRIEF.md
# Display Channel Mode Supervisor

This block decides which of two serial engines owns the data line of a display-identification memory: a free-running transmit-only streamer clocked by the video sync strobe, or a bidirectional I2C slave. After reset the streamer owns the line. The first falling edge of the I2C clock hands the line to the slave in a provisional state. If the slave then reports a matching device-select byte, the hand-over becomes permanent. If it does not, the block returns the line to the streamer after a fixed number of transmit-clock pulses or a timeout, whichever comes first.

Every falling edge of the I2C clock in the provisional state restarts both the pulse count and the timeout. The timeout is counted in ticks of an external prescaled timebase, so a short period can stand in for the nominal two seconds (1.5 s to 3.5 s allowed). A build-time switch selects a variant without recovery: in that variant the first I2C clock falling edge makes the hand-over permanent straight away. All inputs are single-cycle strobes already synchronised to the system clock. Protocol decoding is done elsewhere.

When the block falls back, the streamer carries on from its own address pointer without repeating its synchronisation preamble. That pointer lives in the streamer, not here.

Top module: `ddc_mode_supervisor`

## Requirements
- R1: After reset, `mode` is 0 (transmit-only), `stream_en` is 1 and `slave_en` is 0. The mode codes are 0 = transmit-only, 1 = provisional, 2 = locked. In codes 1 and 2, `slave_en` is 1 and `stream_en` is 0.
- R2: In transmit-only mode, transmit-clock strobes and timebase ticks leave the mode unchanged.
- R3: With recovery enabled, an I2C clock falling-edge strobe in transmit-only mode makes `mode` 1 one cycle later, with the pulse count and tick count at zero.
- R4: In provisional mode, the PULSE_LIMIT-th counted transmit-clock strobe makes `mode` 0 one cycle later. Any earlier strobe leaves it at 1.
- R5: In provisional mode, the TIMEOUT_TICKS-th counted timebase tick makes `mode` 0 one cycle later.
- R6: In provisional mode, an I2C clock falling-edge strobe clears both counts. A further full PULSE_LIMIT strobes, or TIMEOUT_TICKS ticks, are then needed to fall back.
- R7: If an I2C clock falling-edge strobe and a transmit-clock strobe or tick arrive in the same cycle, the clear wins: that strobe or tick is not counted.
- R8: In provisional mode, a device-select strobe makes `mode` 2. It takes precedence over a terminal count arriving in the same cycle.
- R9: Once `mode` is 2, it stays 2 under any input until reset.
- R10: A device-select strobe in transmit-only mode is ignored.
- R11: With recovery disabled (RECOVER_EN = 0), an I2C clock falling-edge strobe in transmit-only mode makes `mode` 2 directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vclk_rise | input | 1 | Transmit-clock rising-edge strobe |
| scl_fall | input | 1 | I2C clock falling-edge strobe |
| dev_sel_ok | input | 1 | Matching device-select decoded strobe |
| tick | input | 1 | Prescaled timebase tick |
| mode | output | 2 | 0 transmit-only, 1 provisional, 2 locked |
| stream_en | output | 1 | Streamer owns the data line |
| slave_en | output | 1 | I2C slave owns the data line |

## Verification
Two collisions are tested, because in each one two functions can fall in the same cycle.

The first is a counter clear landing in the same cycle as a count. The bench raises the pulse count to one below its limit and then issues an I2C clock falling edge together with the would-be final pulse. It judges the result by requiring that `mode` stays 1 and that exactly PULSE_LIMIT further pulses are needed to fall back.

The second is a lock request landing in the same cycle as a terminal count. The bench pairs a device-select strobe with the final pulse, and the outcome must be 2, not 0.

// File: rtl/ddc_mode_pkg.sv
package ddc_mode_pkg;

    typedef enum logic [1:0] {
        MODE_XMIT  = 2'd0,
        MODE_TRANS = 2'd1,
        MODE_LOCK  = 2'd2
    } ddc_mode_e;

    typedef struct packed {
        logic stream_en;
        logic slave_en;
    } ddc_en_t;

    function automatic ddc_en_t mode_enables(ddc_mode_e m);
        ddc_en_t e;
        e.stream_en = (m == MODE_XMIT);
        e.slave_en  = (m != MODE_XMIT);
        return e;
    endfunction

endpackage

// File: rtl/ddc_win_counter.sv
module ddc_win_counter #(
    parameter int LIMIT = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Terminal event: the counted event that would reach LIMIT.
    assign hit = inc && !clr && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ddc_mode_fsm.sv
module ddc_mode_fsm
    import ddc_mode_pkg::*;
#(
    parameter bit RECOVER_EN = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_fall,
    input  logic      dev_sel_ok,
    input  logic      expire,
    output ddc_mode_e state
);
    ddc_mode_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            MODE_XMIT: begin
                if (scl_fall) nxt = RECOVER_EN ? MODE_TRANS : MODE_LOCK;
            end
            MODE_TRANS: begin
                if (dev_sel_ok)    nxt = MODE_LOCK;
                else if (scl_fall) nxt = MODE_TRANS;
                else if (expire)   nxt = MODE_XMIT;
            end
            MODE_LOCK: nxt = MODE_LOCK;
            default:   nxt = MODE_XMIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= MODE_XMIT;
        else     state <= nxt;
    end
endmodule

// File: rtl/ddc_mode_supervisor.sv
module ddc_mode_supervisor
    import ddc_mode_pkg::*;
#(
    parameter int PULSE_LIMIT   = 128,
    parameter int TIMEOUT_TICKS = 2000,
    parameter bit RECOVER_EN    = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vclk_rise,
    input  logic       scl_fall,
    input  logic       dev_sel_ok,
    input  logic       tick,
    output logic [1:0] mode,
    output logic       stream_en,
    output logic       slave_en
);
    ddc_mode_e state;
    ddc_en_t   en;
    logic      win_clr;
    logic      pulse_hit;
    logic      time_hit;

    // Counters run only in the provisional window; any I2C clock fall restarts them.
    assign win_clr = (state != MODE_TRANS) || scl_fall;

    ddc_win_counter #(.LIMIT(PULSE_LIMIT)) u_pulse_cnt (
        .clk (clk),
        .rst (rst),
        .clr (win_clr),
        .inc (vclk_rise),
        .hit (pulse_hit)
    );

    ddc_win_counter #(.LIMIT(TIMEOUT_TICKS)) u_time_cnt (
        .clk (clk),
        .rst (rst),
        .clr (win_clr),
        .inc (tick),
        .hit (time_hit)
    );

    ddc_mode_fsm #(.RECOVER_EN(RECOVER_EN)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .scl_fall   (scl_fall),
        .dev_sel_ok (dev_sel_ok),
        .expire     (pulse_hit || time_hit),
        .state      (state)
    );

    assign en        = mode_enables(state);
    assign mode      = state;
    assign stream_en = en.stream_en;
    assign slave_en  = en.slave_en;
endmodule

// File: rtl/ddc_mode_supervisor_chk.sv
module ddc_mode_supervisor_chk #(
    parameter bit RECOVER_EN = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       scl_fall,
    input logic       dev_sel_ok,
    input logic [1:0] mode,
    input logic       stream_en,
    input logic       slave_en
);
    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        mode == 2'd2 |=> mode == 2'd2);

    // R8
    devsel_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && dev_sel_ok) |=> mode == 2'd2);

    // R6
    scl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && scl_fall) |=> mode != 2'd0);

    // R3
    xmit_leave_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && scl_fall) |=> mode != 2'd0);

    // R10
    no_skip_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (RECOVER_EN && mode == 2'd0) |=> mode != 2'd2);

    // R1
    owner_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot({stream_en, slave_en}));
endmodule

bind ddc_mode_supervisor ddc_mode_supervisor_chk #(.RECOVER_EN(RECOVER_EN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_fall   (scl_fall),
    .dev_sel_ok (dev_sel_ok),
    .mode       (mode),
    .stream_en  (stream_en),
    .slave_en   (slave_en)
);

// File: tb/ddc_mode_supervisor_tb.sv
module ddc_mode_supervisor_tb;
    localparam int LIM = 4;
    localparam int TMO = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vclk_rise = 1'b0, scl_fall = 1'b0, dev_sel_ok = 1'b0, tick = 1'b0;
    logic [1:0] mode, mode_l;
    logic stream_en, slave_en, stream_l, slave_l;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ddc_mode_supervisor #(.PULSE_LIMIT(LIM), .TIMEOUT_TICKS(TMO), .RECOVER_EN(1'b1)) u_dut (
        .clk(clk), .rst(rst), .vclk_rise(vclk_rise), .scl_fall(scl_fall),
        .dev_sel_ok(dev_sel_ok), .tick(tick),
        .mode(mode), .stream_en(stream_en), .slave_en(slave_en));

    ddc_mode_supervisor #(.PULSE_LIMIT(LIM), .TIMEOUT_TICKS(TMO), .RECOVER_EN(1'b0)) u_dut_lock (
        .clk(clk), .rst(rst), .vclk_rise(vclk_rise), .scl_fall(scl_fall),
        .dev_sel_ok(dev_sel_ok), .tick(tick),
        .mode(mode_l), .stream_en(stream_l), .slave_en(slave_l));

    task automatic chk(input logic [1:0] m, input logic se, input logic sl,
                       input logic [1:0] exp, input string req);
        logic exp_se = (exp == 2'd0);
        checks++;
        if (m !== exp || se !== exp_se || sl !== !exp_se) begin
            fails++;
            $display("FAIL %s: mode=%0d stream=%0b slave=%0b expected mode=%0d stream=%0b slave=%0b",
                     req, m, se, sl, exp, exp_se, !exp_se);
        end
    endtask

    // Drive one cycle of strobes; outputs are sampled one full cycle later.
    task automatic drive(input logic v, input logic s, input logic d, input logic t);
        @(negedge clk);
        vclk_rise = v; scl_fall = s; dev_sel_ok = d; tick = t;
        @(negedge clk);
        vclk_rise = 0; scl_fall = 0; dev_sel_ok = 0; tick = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1
        chk(mode, stream_en, slave_en, 2'd0, "R1");
        // R2
        for (int i = 0; i < 2 * TMO; i++) drive(1, 0, 0, 1);
        chk(mode, stream_en, slave_en, 2'd0, "R2");
        // R10
        drive(0, 0, 1, 0);
        chk(mode, stream_en, slave_en, 2'd0, "R10");
        // R3
        drive(0, 1, 0, 0);
        chk(mode, stream_en, slave_en, 2'd1, "R3");
        // R4 sweep over pulse counts
        for (int k = 1; k <= LIM; k++) begin
            drive(1, 0, 0, 0);
            chk(mode, stream_en, slave_en, (k < LIM) ? 2'd1 : 2'd0, "R4");
        end
        // R5 sweep over tick counts
        drive(0, 1, 0, 0);
        for (int k = 1; k <= TMO; k++) begin
            drive(0, 0, 0, 1);
            chk(mode, stream_en, slave_en, (k < TMO) ? 2'd1 : 2'd0, "R5");
        end
        // R6 restart on bus activity, both counters
        drive(0, 1, 0, 0);
        for (int k = 0; k < LIM - 1; k++) drive(1, 0, 0, 1);
        drive(0, 1, 0, 0);
        for (int k = 0; k < LIM - 1; k++) drive(1, 0, 0, 0);
        chk(mode, stream_en, slave_en, 2'd1, "R6");
        drive(1, 0, 0, 0);
        chk(mode, stream_en, slave_en, 2'd0, "R6");
        // R7 clear collides with terminal pulse
        drive(0, 1, 0, 0);
        for (int k = 0; k < LIM - 1; k++) drive(1, 0, 0, 0);
        drive(1, 1, 0, 1);
        chk(mode, stream_en, slave_en, 2'd1, "R7");
        for (int k = 1; k <= LIM; k++) begin
            drive(1, 0, 0, 0);
            chk(mode, stream_en, slave_en, (k < LIM) ? 2'd1 : 2'd0, "R7");
        end
        // R8 lock beats terminal count
        drive(0, 1, 0, 0);
        for (int k = 0; k < LIM - 1; k++) drive(1, 0, 0, 0);
        drive(1, 0, 1, 0);
        chk(mode, stream_en, slave_en, 2'd2, "R8");
        // R9 sticky lock
        for (int k = 0; k < 2 * TMO; k++) begin
            drive(1, k[0], 0, 1);
            chk(mode, stream_en, slave_en, 2'd2, "R9");
        end
        // R8 plain lock after timeout-terminal collision
        do_reset();
        drive(0, 1, 0, 0);
        for (int k = 0; k < TMO - 1; k++) drive(0, 0, 0, 1);
        drive(0, 0, 1, 1);
        chk(mode, stream_en, slave_en, 2'd2, "R8");
        // R11 non-recovering variant
        do_reset();
        chk(mode_l, stream_l, slave_l, 2'd0, "R11");
        drive(0, 1, 0, 0);
        chk(mode_l, stream_l, slave_l, 2'd2, "R11");
        for (int k = 0; k < 2 * LIM; k++) drive(1, 0, 0, 1);
        chk(mode_l, stream_l, slave_l, 2'd2, "R11");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule